// File: doc/BRIEF.md
# Flash unlock command sequence decoder

This block sits on the write side of a byte-wide parallel flash model. Each write cycle reaches it as a one-clock strobe with the address and data already latched. It follows the multi-cycle unlock protocol that guards the array and turns each complete, well-formed sequence into a one-clock request to a downstream engine. The engine handles chip erase, byte program, boot-region lockout, and entry to or exit from the identification mode.

Every long sequence begins with the same two key writes. The third write picks a branch: program, extended command, ID entry or ID exit. The extended branch repeats the two keys and then takes its final opcode in the sixth write. For a program, the fourth write carries the target address and data. The block captures them and holds them for the engine. A write that does not fit the expected step drops the sequence without a request. While the engine reports busy, writes are not accepted and any partial sequence is abandoned. The block also keeps the identification-mode flag.

Top module: `cmdseq_decoder`

## Requirements
- R1: After reset, every request output and `id_mode` are 0, and `prog_addr` and `prog_data` are 0.
- R2: The writes AA@5555, 55@2AAA, A0@5555 and then any data D at any address A raise `req_prog` for one clock, in the clock after the fourth accepted strobe, with `prog_addr`=A and `prog_data`=D.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 raise `req_erase` for one clock after the sixth strobe. Any other sixth data raises no request.
- R4: The same five-write prefix as R3, followed by 40@5555, raises `req_lock` for one clock after the sixth strobe.
- R5: The writes AA@5555, 55@2AAA, 90@5555 raise `req_id_enter` for one clock and set `id_mode` to 1 in the same clock. No other third-cycle data except A0, 80 and F0 does anything.
- R6: The writes AA@5555, 55@2AAA, F0@5555 raise `req_id_exit` for one clock and clear `id_mode`.
- R7: With no sequence in progress, a single write of F0 to any address raises `req_id_exit` and clears `id_mode`. An F0 written in the middle of a sequence only aborts that sequence.
- R8: A write whose address or data does not fit the expected step returns the decoder to idle with no request. That write does not count as a new first key.
- R9: While `eng_busy` is 1, `wr_accept` is 0, strobes are ignored, and any partial sequence is discarded, even if no write arrives during the busy period.
- R10: The request outputs are one-clock pulses, at most one is high in any clock, and each follows an accepted strobe.
- R11: `prog_addr` and `prog_data` change only when `req_prog` is raised and hold their values through all other commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-clock write cycle strobe |
| wr_addr | input | 16 | Latched write address |
| wr_data | input | 8 | Latched write data |
| eng_busy | input | 1 | Downstream engine busy |
| wr_accept | output | 1 | Strobe taken this clock |
| req_erase | output | 1 | Chip erase request pulse |
| req_prog | output | 1 | Byte program request pulse |
| req_lock | output | 1 | Boot-region lockout request pulse |
| req_id_enter | output | 1 | Identification mode entry pulse |
| req_id_exit | output | 1 | Identification mode exit pulse |
| id_mode | output | 1 | Identification mode flag |
| prog_addr | output | 16 | Captured program target address |
| prog_data | output | 8 | Captured program data |

## Verification
The assertions assume that a strobe lasts exactly one clock and that address and data are stable while it is high. The bench raises `wr_stb` for a single clock per write and changes its inputs only on the falling edge. The assertions also assume that the engine's busy signal is independent of the requests. The bench therefore drives busy only in dedicated phases, away from any pending pulse. The sweeps walk every third-cycle and sixth-cycle data value and every single-bit corruption of the first key address, and they predict each outcome from the opcode tables in the requirements.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_KEY1,
      S_KEY2,
      S_TARGET,
      S_EXT1,
      S_EXT2,
      S_EXT3
   } seq_t;

   typedef struct packed {
      logic erase;
      logic prog;
      logic lock;
      logic id_in;
      logic id_out;
   } evt_t;

   localparam logic [7:0]  CODE_KEY1   = 8'hAA;
   localparam logic [7:0]  CODE_KEY2   = 8'h55;
   localparam logic [7:0]  OP_PROGRAM  = 8'hA0;
   localparam logic [7:0]  OP_EXTEND   = 8'h80;
   localparam logic [7:0]  OP_ID_IN    = 8'h90;
   localparam logic [7:0]  OP_ID_OUT   = 8'hF0;
   localparam logic [7:0]  OP_ERASE    = 8'h10;
   localparam logic [7:0]  OP_LOCK     = 8'h40;
   localparam logic [15:0] ADDR_KEY1   = 16'h5555;
   localparam logic [15:0] ADDR_KEY2   = 16'h2AAA;

endpackage

// File: rtl/cmdseq_match.sv
module cmdseq_match #(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned MATCH_W = 16,
   parameter logic [ADDR_W-1:0] KEY1 = '0,
   parameter logic [ADDR_W-1:0] KEY2 = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              at_key1,
   output logic              at_key2
);

   generate
      if (MATCH_W >= ADDR_W) begin : g_full
         assign at_key1 = (addr == KEY1);
         assign at_key2 = (addr == KEY2);
      end else begin : g_partial
         assign at_key1 = (addr[MATCH_W-1:0] == KEY1[MATCH_W-1:0]);
         assign at_key2 = (addr[MATCH_W-1:0] == KEY2[MATCH_W-1:0]);
      end
   endgenerate

endmodule

// File: rtl/cmdseq_fsm.sv
module cmdseq_fsm
   import cmdseq_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              busy,
   input  logic              at_key1,
   input  logic              at_key2,
   input  logic [DATA_W-1:0] data,
   output evt_t              evt
);

   localparam logic [DATA_W-1:0] K1  = DATA_W'(CODE_KEY1);
   localparam logic [DATA_W-1:0] K2  = DATA_W'(CODE_KEY2);
   localparam logic [DATA_W-1:0] PRG = DATA_W'(OP_PROGRAM);
   localparam logic [DATA_W-1:0] EXT = DATA_W'(OP_EXTEND);
   localparam logic [DATA_W-1:0] IDI = DATA_W'(OP_ID_IN);
   localparam logic [DATA_W-1:0] IDO = DATA_W'(OP_ID_OUT);
   localparam logic [DATA_W-1:0] ERS = DATA_W'(OP_ERASE);
   localparam logic [DATA_W-1:0] LCK = DATA_W'(OP_LOCK);

   seq_t st, nxt;

   always_comb begin
      nxt = st;
      evt = '0;
      if (busy) begin
         nxt = S_IDLE;
      end else if (take) begin
         nxt = S_IDLE;
         unique case (st)
            S_IDLE: begin
               if (at_key1 && data == K1)  nxt = S_KEY1;
               else if (data == IDO)       evt.id_out = 1'b1;
            end
            S_KEY1: if (at_key2 && data == K2) nxt = S_KEY2;
            S_KEY2: begin
               if (at_key1) begin
                  if (data == PRG)      nxt = S_TARGET;
                  else if (data == EXT) nxt = S_EXT1;
                  else if (data == IDI) evt.id_in  = 1'b1;
                  else if (data == IDO) evt.id_out = 1'b1;
               end
            end
            S_TARGET: evt.prog = 1'b1;
            S_EXT1: if (at_key1 && data == K1) nxt = S_EXT2;
            S_EXT2: if (at_key2 && data == K2) nxt = S_EXT3;
            S_EXT3: begin
               if (at_key1) begin
                  if (data == ERS)      evt.erase = 1'b1;
                  else if (data == LCK) evt.lock  = 1'b1;
               end
            end
            default: nxt = S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= S_IDLE;
      else        st <= nxt;
   end

   // R9: a busy clock leaves no sequence behind
   p_busy_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (st == S_IDLE));

   // R2: the program target step is reached only from the third-cycle state
   p_target_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_TARGET && $past(st) != S_TARGET) |-> ($past(st) == S_KEY2));

   // R3, R4: the last extended step follows the repeated second key
   p_ext3_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_EXT3 && $past(st) != S_EXT3) |-> ($past(st) == S_EXT2));

endmodule

// File: rtl/cmdseq_regs.sv
module cmdseq_regs
   import cmdseq_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  evt_t              evt,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              req_erase,
   output logic              req_prog,
   output logic              req_lock,
   output logic              req_id_enter,
   output logic              req_id_exit,
   output logic              id_mode,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_erase    <= 1'b0;
         req_prog     <= 1'b0;
         req_lock     <= 1'b0;
         req_id_enter <= 1'b0;
         req_id_exit  <= 1'b0;
         id_mode      <= 1'b0;
         prog_addr    <= '0;
         prog_data    <= '0;
      end else begin
         req_erase    <= evt.erase;
         req_prog     <= evt.prog;
         req_lock     <= evt.lock;
         req_id_enter <= evt.id_in;
         req_id_exit  <= evt.id_out;
         if (evt.id_in)       id_mode <= 1'b1;
         else if (evt.id_out) id_mode <= 1'b0;
         if (evt.prog) begin
            prog_addr <= addr;
            prog_data <= data;
         end
      end
   end

   p_one_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_erase, req_prog, req_lock, req_id_enter, req_id_exit}));

   p_erase_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_erase || req_lock) |=> !(req_erase || req_lock));

   p_prog_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_prog |-> ($stable(prog_addr) && $stable(prog_data)));

   p_enter_sets_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_id_enter |-> id_mode);

   p_exit_clears_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_id_exit |-> !id_mode);

endmodule

// File: rtl/cmdseq_decoder.sv
module cmdseq_decoder
   import cmdseq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned MATCH_W = ADDR_W,
   parameter logic [ADDR_W-1:0] KEY1_ADDR = ADDR_W'(ADDR_KEY1),
   parameter logic [ADDR_W-1:0] KEY2_ADDR = ADDR_W'(ADDR_KEY2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              eng_busy,
   output logic              wr_accept,
   output logic              req_erase,
   output logic              req_prog,
   output logic              req_lock,
   output logic              req_id_enter,
   output logic              req_id_exit,
   output logic              id_mode,
   output logic [ADDR_W-1:0] prog_addr,
   output logic [DATA_W-1:0] prog_data
);

   initial begin
      a_data_width: assert (DATA_W >= 8)
         else $error("DATA_W must hold an 8-bit command code");
      a_match_width: assert (MATCH_W >= 1 && MATCH_W <= ADDR_W)
         else $error("MATCH_W must lie in 1..ADDR_W");
   end

   logic at_key1, at_key2;
   evt_t evt;

   assign wr_accept = wr_stb & ~eng_busy;

   cmdseq_match #(
      .ADDR_W (ADDR_W),
      .MATCH_W(MATCH_W),
      .KEY1   (KEY1_ADDR),
      .KEY2   (KEY2_ADDR)
   ) u_match (
      .addr   (wr_addr),
      .at_key1(at_key1),
      .at_key2(at_key2)
   );

   cmdseq_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (wr_accept),
      .busy   (eng_busy),
      .at_key1(at_key1),
      .at_key2(at_key2),
      .data   (wr_data),
      .evt    (evt)
   );

   cmdseq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (evt),
      .addr        (wr_addr),
      .data        (wr_data),
      .req_erase   (req_erase),
      .req_prog    (req_prog),
      .req_lock    (req_lock),
      .req_id_enter(req_id_enter),
      .req_id_exit (req_id_exit),
      .id_mode     (id_mode),
      .prog_addr   (prog_addr),
      .prog_data   (prog_data)
   );

   // R9, R10: every request follows a strobe that was taken
   p_req_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_erase || req_prog || req_lock || req_id_enter || req_id_exit)
         |-> $past(wr_accept));

endmodule

// File: tb/cmdseq_decoder_test.sv
`timescale 1ns/1ps
module cmdseq_decoder_test;

   localparam logic [4:0] E_NONE  = 5'b00000;
   localparam logic [4:0] E_ERASE = 5'b10000;
   localparam logic [4:0] E_PROG  = 5'b01000;
   localparam logic [4:0] E_LOCK  = 5'b00100;
   localparam logic [4:0] E_ENTER = 5'b00010;
   localparam logic [4:0] E_EXIT  = 5'b00001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        eng_busy = 1'b0;
   logic        wr_accept, req_erase, req_prog, req_lock, req_id_enter, req_id_exit, id_mode;
   logic [15:0] prog_addr;
   logic [7:0]  prog_data;

   int n_checks = 0;
   int n_fail = 0;
   logic exp_mode = 1'b0;

   always #4 clk = ~clk;

   cmdseq_decoder uut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .eng_busy(eng_busy), .wr_accept(wr_accept), .req_erase(req_erase), .req_prog(req_prog),
      .req_lock(req_lock), .req_id_enter(req_id_enter), .req_id_exit(req_id_exit),
      .id_mode(id_mode), .prog_addr(prog_addr), .prog_data(prog_data)
   );

   function automatic logic [4:0] reqs();
      return {req_erase, req_prog, req_lock, req_id_enter, req_id_exit};
   endfunction

   task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // one write cycle; request vector checked in the clock after the strobe
   task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [4:0] exp, input string req);
      @(negedge clk);
      wr_stb = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_stb = 1'b0;
      check(reqs() == exp, req, 32'(reqs()), 32'(exp));
      if (exp[1]) exp_mode = 1'b1;
      if (exp[0]) exp_mode = 1'b0;
      check(id_mode == exp_mode, {req, " id_mode"}, 32'(id_mode), 32'(exp_mode));
   endtask

   task automatic quiet(input string req);
      @(negedge clk);
      check(reqs() == E_NONE, req, 32'(reqs()), 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] pa;
      logic [7:0]  pd;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(reqs() == E_NONE, "R1 requests", 32'(reqs()), 0);
      check(id_mode == 1'b0, "R1 id_mode", 32'(id_mode), 0);
      check(prog_addr == 16'h0 && prog_data == 8'h0, "R1 prog regs", {prog_addr, prog_data}, 0);
      rst_n = 1'b1;

      // R5 R6 R2: sweep every third-cycle data value, followed by a probe write
      for (int v = 0; v < 256; v++) begin
         logic [4:0] e3, e4;
         logic [15:0] ja;
         e3 = (v == 8'h90) ? E_ENTER : (v == 8'hF0) ? E_EXIT : E_NONE;
         e4 = (v == 8'hA0) ? E_PROG : E_NONE;
         ja = {8'(v), ~8'(v)};
         wr(16'h5555, 8'hAA, E_NONE, "R5 key1");
         wr(16'h2AAA, 8'h55, E_NONE, "R5 key2");
         wr(16'h5555, 8'(v), e3, "R5 R6 third cycle");
         wr(ja, 8'h00, e4, "R2 R8 probe write");
         if (v == 8'hA0)
            check(prog_addr == ja && prog_data == 8'h00, "R2 capture", {prog_addr, prog_data}, {ja, 8'h00});
         quiet("R10 pulse width");
      end

      // R3 R4: sweep every sixth-cycle data value
      for (int v = 0; v < 256; v++) begin
         logic [4:0] e6;
         e6 = (v == 8'h10) ? E_ERASE : (v == 8'h40) ? E_LOCK : E_NONE;
         wr(16'h5555, 8'hAA, E_NONE, "R3 c1");
         wr(16'h2AAA, 8'h55, E_NONE, "R3 c2");
         wr(16'h5555, 8'h80, E_NONE, "R3 c3");
         wr(16'h5555, 8'hAA, E_NONE, "R3 c4");
         wr(16'h2AAA, 8'h55, E_NONE, "R3 c5");
         wr(16'h5555, 8'(v), e6, "R3 R4 sixth cycle");
         quiet("R10 pulse width");
      end
      // sixth cycle at wrong address
      wr(16'h5555, 8'hAA, E_NONE, "R8 c1"); wr(16'h2AAA, 8'h55, E_NONE, "R8 c2");
      wr(16'h5555, 8'h80, E_NONE, "R8 c3"); wr(16'h5555, 8'hAA, E_NONE, "R8 c4");
      wr(16'h2AAA, 8'h55, E_NONE, "R8 c5"); wr(16'h5554, 8'h10, E_NONE, "R8 sixth address");

      // R8: single-bit corruption of the first key address aborts the sequence
      for (int b = 0; b < 16; b++) begin
         wr(16'h5555 ^ (16'h1 << b), 8'hAA, E_NONE, "R8 bad key1 addr");
         wr(16'h2AAA, 8'h55, E_NONE, "R8 after bad");
         wr(16'h5555, 8'h90, E_NONE, "R8 no entry");
      end
      // R8: a bad second cycle that is itself a first key does not restart
      wr(16'h5555, 8'hAA, E_NONE, "R8 k1");
      wr(16'h5555, 8'hAA, E_NONE, "R8 repeated k1");
      wr(16'h2AAA, 8'h55, E_NONE, "R8 k2");
      wr(16'h5555, 8'h90, E_NONE, "R8 no restart");

      // R7: short exit at several addresses, and F0 mid-sequence
      for (int i = 0; i < 4; i++) begin
         logic [15:0] xa;
         xa = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : (i == 2) ? 16'h5555 : 16'h1234;
         wr(16'h5555, 8'hAA, E_NONE, "R7 set c1");
         wr(16'h2AAA, 8'h55, E_NONE, "R7 set c2");
         wr(16'h5555, 8'h90, E_ENTER, "R7 set mode");
         wr(xa, 8'hF0, E_EXIT, "R7 short exit");
      end
      wr(16'h5555, 8'hAA, E_NONE, "R7 c1"); wr(16'h2AAA, 8'h55, E_NONE, "R7 c2");
      wr(16'h5555, 8'h90, E_ENTER, "R7 enter");
      wr(16'h5555, 8'hAA, E_NONE, "R7 partial");
      wr(16'h1234, 8'hF0, E_NONE, "R7 F0 mid-sequence aborts only");
      wr(16'h0042, 8'hF0, E_EXIT, "R7 exit afterwards");

      // R11: program capture held through other commands
      pa = 16'hBEEF; pd = 8'h5A;
      wr(16'h5555, 8'hAA, E_NONE, "R11 c1"); wr(16'h2AAA, 8'h55, E_NONE, "R11 c2");
      wr(16'h5555, 8'hA0, E_NONE, "R11 c3"); wr(pa, pd, E_PROG, "R11 program");
      wr(16'h5555, 8'hAA, E_NONE, "R11 e1"); wr(16'h2AAA, 8'h55, E_NONE, "R11 e2");
      wr(16'h5555, 8'h80, E_NONE, "R11 e3"); wr(16'h5555, 8'hAA, E_NONE, "R11 e4");
      wr(16'h2AAA, 8'h55, E_NONE, "R11 e5"); wr(16'h5555, 8'h10, E_ERASE, "R11 erase");
      wr(16'h7777, 8'hF0, E_EXIT, "R11 exit");
      check(prog_addr == pa && prog_data == pd, "R11 hold", {prog_addr, prog_data}, {pa, pd});

      // R9: busy ignores writes and discards partial sequences
      @(negedge clk);
      eng_busy = 1'b1; wr_stb = 1'b1; wr_addr = 16'h5555; wr_data = 8'hAA;
      #1 check(wr_accept == 1'b0, "R9 accept low", 32'(wr_accept), 0);
      @(negedge clk);
      wr_stb = 1'b0; eng_busy = 1'b0;
      check(reqs() == E_NONE, "R9 busy write", 32'(reqs()), 0);
      wr(16'h2AAA, 8'h55, E_NONE, "R9 after busy");
      wr(16'h5555, 8'h90, E_NONE, "R9 no entry");
      wr(16'h5555, 8'hAA, E_NONE, "R9 k1"); wr(16'h2AAA, 8'h55, E_NONE, "R9 k2");
      @(negedge clk); eng_busy = 1'b1;
      @(negedge clk); eng_busy = 1'b0;
      wr(16'h5555, 8'h90, E_NONE, "R9 idle busy discards");
      @(negedge clk);
      eng_busy = 1'b1; wr_stb = 1'b1; wr_addr = 16'h0000; wr_data = 8'hF0;
      @(negedge clk);
      wr_stb = 1'b0; eng_busy = 1'b0;
      check(reqs() == E_NONE, "R9 short exit ignored", 32'(reqs()), 0);

      finish_run();
   end

endmodule